// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps one 8-bit register of timer event flags and turns them into interrupt requests. Three timers report their events as one-cycle pulses: compare matches, an input capture, and counter overflows. The block latches each pulse into its flag bit. A flag stays set until software writes a one to that bit, or until the processor acknowledges the interrupt vector that belongs to it. A flag issues a request only when its own enable bit and the global interrupt enable are both set.

Overflow flags are set by one of two counter conditions, chosen per timer. In normal counting, the flag is set when the counter wraps past its top value. In PWM mode, the flag is set when the counter steps away from zero. The timers send both conditions as separate pulses. The block picks one of them according to the timer's PWM mode input and ignores the other.

The pending requests feed a priority encoder. It offers a vector with `vec_valid`/`vec_idx`, and the highest pending bit number wins. An acknowledge needs no ready: any cycle with `ack_valid` high is accepted, and `ack_idx` names the flag to clear. The index may change from one cycle to the next as flags come and go. The consumer acknowledges the index it took.

Two registers sit on a simple bus, with no wait states and a combinational read. `bus_addr` 0 selects the flag register and `bus_addr` 1 selects the enable register.

Top module: `tifc_top`

## Requirements
- R1: After reset, the flag register and the enable register both read 0, `irq_req` is 0 and `vec_valid` is 0.
- R2: A pulse on `evt_pulse` at a compare or capture position sets that flag at the next clock edge. The positions are bit 7 (compare, timer 2), bit 5 (capture, timer 1), bit 4 (compare A, timer 1), bit 3 (compare B, timer 1) and bit 1 (compare, timer 0).
- R3: With `tmr_pwm[t]` at 0, a `tmr_wrap[t]` pulse sets the overflow flag of timer t and a `tmr_leave_zero[t]` pulse has no effect. The overflow flag is bit 0 for timer 0, bit 2 for timer 1 and bit 6 for timer 2.
- R4: With `tmr_pwm[t]` at 1, a `tmr_leave_zero[t]` pulse sets the overflow flag of timer t and a `tmr_wrap[t]` pulse has no effect.
- R5: A flag-register write (`bus_addr`=0) clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R6: `ack_valid` with `ack_idx`=k clears flag k only, at the next edge.
- R7: If a set event and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag ends up at 1.
- R8: `irq_req[k]` is 1 exactly when `gie`, enable bit k and flag k are all 1.
- R9: `vec_valid` is 1 when any `irq_req` bit is 1. `vec_idx` is then the highest bit number with a request.
- R10: The enable register (`bus_addr`=1) takes `bus_wdata` on a write and reads back unchanged.
- R11: `evt_pulse` bits at the overflow positions 6, 2 and 0 are ignored.
- R12: `bus_rdata` shows the selected register in the same cycle. A flag change is visible the cycle after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gie | input | 1 | Global interrupt enable |
| evt_pulse | input | 8 | Compare/capture event pulses, one per flag position |
| tmr_wrap | input | 3 | Per-timer pulse: counter wrapped past top |
| tmr_leave_zero | input | 3 | Per-timer pulse: counter advanced from zero |
| tmr_pwm | input | 3 | Per-timer PWM mode select |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 flags, 1 enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_req | output | 8 | Per-flag interrupt request |
| vec_valid | output | 1 | A vector is offered |
| vec_idx | output | 3 | Offered vector index |
| ack_valid | input | 1 | Vector acknowledge, always accepted |
| ack_idx | input | 3 | Index of the acknowledged flag |

## Verification
The clearing properties assume that no timer event arrives in the cycle of the write or acknowledge under test. Without that, a set would legally override the clear. The directed stimulus keeps the two apart, except in the one scenario that merges them on purpose to show that the set wins. The bench also assumes that every event input is a single-cycle pulse and that the bus is idle whenever it is not writing. The tasks release every strobe on the next falling edge.

// File: rtl/tifc_pkg.sv
package tifc_pkg;
  localparam int NFLAG = 8;
  localparam int IDXW  = $clog2(NFLAG);
  localparam int NTMR  = 3;

  // Overflow flag position per timer index
  function automatic int ovf_pos(input int t);
    case (t)
      0:       return 0;
      1:       return 2;
      default: return 6;
    endcase
  endfunction

  function automatic logic [NFLAG-1:0] ovf_mask();
    logic [NFLAG-1:0] m;
    m = '0;
    for (int t = 0; t < NTMR; t++) m[ovf_pos(t)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tifc_ovf_select.sv
module tifc_ovf_select
  import tifc_pkg::*;
#(
  parameter int N_TMR = NTMR,
  parameter int W     = NFLAG
) (
  input  logic [N_TMR-1:0] pwm_mode,
  input  logic [N_TMR-1:0] wrap,
  input  logic [N_TMR-1:0] leave_zero,
  output logic [W-1:0]     ovf_set
);
  logic [N_TMR-1:0] pick;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    // PWM mode counts leaving zero; normal mode counts wrap past top
    assign pick[t] = pwm_mode[t] ? leave_zero[t] : wrap[t];
  end

  always_comb begin
    ovf_set = '0;
    for (int t = 0; t < N_TMR; t++) ovf_set[ovf_pos(t)] = pick[t];
  end
endmodule

// File: rtl/tifc_flag_bank.sv
module tifc_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (set_mask[i]) flags[i] <= 1'b1;   // set dominates clear
      else if (clr_mask[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tifc_prio_enc.sv
module tifc_prio_enc #(
  parameter int W    = 8,
  parameter int IW   = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++)
      if (req[i]) idx = IW'(i);   // ascending scan: highest bit wins
  end
  assign valid = |req;
endmodule

// File: rtl/tifc_top.sv
module tifc_top
  import tifc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gie,
  input  logic [NFLAG-1:0] evt_pulse,
  input  logic [NTMR-1:0]  tmr_wrap,
  input  logic [NTMR-1:0]  tmr_leave_zero,
  input  logic [NTMR-1:0]  tmr_pwm,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [NFLAG-1:0] bus_wdata,
  output logic [NFLAG-1:0] bus_rdata,
  output logic [NFLAG-1:0] irq_req,
  output logic             vec_valid,
  output logic [IDXW-1:0]  vec_idx,
  input  logic             ack_valid,
  input  logic [IDXW-1:0]  ack_idx
);
  localparam logic [NFLAG-1:0] OVF_BITS = ovf_mask();

  logic [NFLAG-1:0] flags_q, en_q, ovf_set, set_mask, clr_mask, ack_mask;

  tifc_ovf_select #(.N_TMR(NTMR), .W(NFLAG)) u_ovf (
    .pwm_mode(tmr_pwm), .wrap(tmr_wrap), .leave_zero(tmr_leave_zero),
    .ovf_set(ovf_set)
  );

  assign set_mask = (evt_pulse & ~OVF_BITS) | ovf_set;
  assign ack_mask = ack_valid ? (NFLAG'(1) << ack_idx) : '0;
  assign clr_mask = ((bus_we && !bus_addr) ? bus_wdata : '0) | ack_mask;

  tifc_flag_bank #(.W(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .flags(flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_q <= '0;
    else if (bus_we && bus_addr) en_q <= bus_wdata;
  end

  assign bus_rdata = bus_addr ? en_q : flags_q;
  assign irq_req   = flags_q & en_q & {NFLAG{gie}};

  tifc_prio_enc #(.W(NFLAG), .IW(IDXW)) u_prio (
    .req(irq_req), .valid(vec_valid), .idx(vec_idx)
  );
endmodule

// File: rtl/tifc_checker.sv
module tifc_checker
  import tifc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic [NFLAG-1:0] evt_pulse,
  input logic [NTMR-1:0]  tmr_wrap,
  input logic [NTMR-1:0]  tmr_leave_zero,
  input logic             bus_we,
  input logic             bus_addr,
  input logic [NFLAG-1:0] bus_wdata,
  input logic [NFLAG-1:0] irq_req,
  input logic             vec_valid,
  input logic [IDXW-1:0]  vec_idx,
  input logic             ack_valid,
  input logic [IDXW-1:0]  ack_idx,
  input logic [NFLAG-1:0] flags_q,
  input logic [NFLAG-1:0] en_q
);
  localparam logic [NFLAG-1:0] CC_BITS = ~ovf_mask();
  logic quiet;
  assign quiet = (evt_pulse == '0) && (tmr_wrap == '0) && (tmr_leave_zero == '0);

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_pulse & CC_BITS) |=> ((flags_q & $past(evt_pulse & CC_BITS)) == $past(evt_pulse & CC_BITS)));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr && quiet) |=> ((flags_q & $past(bus_wdata)) == '0));

  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && quiet && !bus_we) |=> (flags_q == ($past(flags_q) & ~(NFLAG'(1) << $past(ack_idx)))));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0 && !vec_valid));

  p_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (flags_q[vec_idx] && en_q[vec_idx] && ((irq_req >> vec_idx) == 1)));

  p_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr) |=> (en_q == $past(bus_wdata)));
endmodule

bind tifc_top tifc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .evt_pulse(evt_pulse),
  .tmr_wrap(tmr_wrap), .tmr_leave_zero(tmr_leave_zero),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_req(irq_req), .vec_valid(vec_valid), .vec_idx(vec_idx),
  .ack_valid(ack_valid), .ack_idx(ack_idx), .flags_q(flags_q), .en_q(en_q)
);

// File: tb/tb_tifc_top.sv
module tb_tifc_top;
  logic clk = 1'b0, rst_n = 1'b0, gie = 1'b0;
  logic [7:0] evt_pulse = '0, bus_wdata = '0;
  logic [2:0] tmr_wrap = '0, tmr_leave_zero = '0, tmr_pwm = '0, ack_idx = '0;
  logic bus_we = 1'b0, bus_addr = 1'b0, ack_valid = 1'b0;
  logic [7:0] bus_rdata, irq_req;
  logic vec_valid;
  logic [2:0] vec_idx;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tifc_top dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic pulse_tmr(input logic [2:0] w, input logic [2:0] z);
    @(negedge clk); tmr_wrap = w; tmr_leave_zero = z;
    @(negedge clk); tmr_wrap = '0; tmr_leave_zero = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 flags", d, 0);
    rd(1, d); chk("R1 enables", d, 0);
    chk("R1 irq", irq_req, 0); chk("R1 vec_valid", vec_valid, 0);
  endtask

  task automatic t_compare();
    logic [7:0] d;
    pulse_evt(8'h80); rd(0, d); chk("R2 compare2 bit7", d, 8'h80);
    pulse_evt(8'h3A); rd(0, d); chk("R2 capture/compare bits", d, 8'hBA);
    wr(0, 8'hFF);
    pulse_evt(8'h45); rd(0, d); chk("R11 ovf positions ignored", d, 0);
  endtask

  task automatic t_ovf_normal();
    logic [7:0] d;
    tmr_pwm = 3'b000;
    pulse_tmr(3'b000, 3'b111); rd(0, d); chk("R3 leave-zero ignored", d, 0);
    pulse_tmr(3'b010, 3'b000); rd(0, d); chk("R3 wrap t1 bit2", d, 8'h04);
    pulse_tmr(3'b101, 3'b000); rd(0, d); chk("R3 wrap t0,t2", d, 8'h45);
    wr(0, 8'hFF);
  endtask

  task automatic t_ovf_pwm();
    logic [7:0] d;
    tmr_pwm = 3'b111;
    pulse_tmr(3'b111, 3'b000); rd(0, d); chk("R4 wrap ignored", d, 0);
    pulse_tmr(3'b000, 3'b100); rd(0, d); chk("R4 leave-zero t2 bit6", d, 8'h40);
    tmr_pwm = 3'b010;
    pulse_tmr(3'b001, 3'b010); rd(0, d); chk("R4 mixed modes", d, 8'h45);
    tmr_pwm = 3'b000;
    wr(0, 8'hFF);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    pulse_evt(8'hBA); pulse_tmr(3'b111, 3'b000);
    rd(0, d); chk("R12 all flags set", d, 8'hFF);
    wr(0, 8'h0F); rd(0, d); chk("R5 clear low nibble", d, 8'hF0);
    wr(0, 8'h00); rd(0, d); chk("R5 zero write no effect", d, 8'hF0);
    wr(0, 8'hFF); rd(0, d); chk("R5 clear all", d, 0);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    pulse_evt(8'hB0);
    @(negedge clk); ack_valid = 1; ack_idx = 3'd5;
    @(negedge clk); ack_valid = 0;
    rd(0, d); chk("R6 ack clears only bit5", d, 8'h90);
    wr(0, 8'hFF);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk); evt_pulse = 8'h80; bus_we = 1; bus_addr = 0; bus_wdata = 8'h80;
    @(negedge clk); evt_pulse = 0; bus_we = 0; bus_wdata = 0;
    rd(0, d); chk("R7 set beats write clear", d, 8'h80);
    @(negedge clk); evt_pulse = 8'h20; ack_valid = 1; ack_idx = 3'd5;
    @(negedge clk); evt_pulse = 0; ack_valid = 0;
    rd(0, d); chk("R7 set beats ack", d, 8'hA0);
    wr(0, 8'hFF);
  endtask

  task automatic t_irq_prio();
    logic [7:0] d;
    wr(1, 8'hFF); rd(1, d); chk("R10 enable readback", d, 8'hFF);
    pulse_evt(8'h2A);
    gie = 0; #1; chk("R8 gie off no req", irq_req, 0); chk("R9 no vector", vec_valid, 0);
    gie = 1; #1; chk("R8 req pattern", irq_req, 8'h2A);
    chk("R9 valid", vec_valid, 1); chk("R9 highest idx", vec_idx, 5);
    wr(1, 8'hDF); #1; chk("R8 enable masks bit5", irq_req, 8'h0A);
    chk("R9 next idx", vec_idx, 3);
    pulse_tmr(3'b001, 3'b000); #1; chk("R9 still idx3", vec_idx, 3);
    wr(1, 8'h01); #1; chk("R9 idx0", vec_idx, 0);
    rd(1, d); chk("R10 enable value", d, 8'h01);
    gie = 0; wr(0, 8'hFF); wr(1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_compare();
    t_ovf_normal();
    t_ovf_pwm();
    t_w1c();
    t_ack();
    t_set_wins();
    t_irq_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule